// File: doc/BRIEF.md
# Variable-Length Bitstream Reader

This block turns a run of packed data in memory into a 16-bit window that software can advance by any number of bits from 1 to 16. Software writes a 24-bit start address one byte at a time. Writing the top address byte fetches the first 16-bit word and opens the stream. Each later write of a shift amount drops that many bits from the bottom of the window. The block fetches the next word whenever fewer than 16 valid bits are left, so the window always holds a full 16 bits of the stream once the block is idle.

Memory is reached through a single-word request/valid port. The memory returns a little-endian word: the byte at the requested address appears in bits 7:0, and the byte at the next address appears in bits 15:8. The window is read back one byte at a time through a select input. A busy flag marks the time between a word request and its arrival. A shift written during that time is held and applied after the word arrives.

Top module: `bitstream_reader`

## Requirements
- R1: After reset the address is zero, no word is requested, busy is low, and both window bytes read as zero.
- R2: Writing with select 0 (address bits 7:0) or select 1 (address bits 15:8) only stages a byte and requests nothing. Writing with select 2 (address bits 23:16) forms the full 24-bit address and requests the word at that address.
- R3: When the first word arrives, the window equals that word, 16 bits are valid, and the stored address advances by 2.
- R4: A write with select 3 takes bits 3:0 of the data as the shift amount. The value 0 means 16 bits, and bits 7:4 are ignored.
- R5: A shift moves the bit buffer right by the shift amount, so the window shows the stream starting that many bits further on.
- R6: If fewer than 16 valid bits remain after a shift, the word at the current address is requested and placed directly above the remaining bits. The count then grows by 16, and the address advances by 2.
- R7: If 16 or more valid bits remain after a shift, no word is requested.
- R8: Busy and the request stay high, with a steady address, from the moment a word is requested until the valid cycle that delivers it.
- R9: A shift written while busy, including in the cycle the word arrives, is held and applied once the word has been merged. A second such write replaces the first.
- R10: Read select 0 returns window bits 7:0 and select 1 returns bits 15:8. While busy, the read returns the current buffer, in which bits above the remaining valid count are zero.
- R11: A shift written before any stream has been started is ignored.
- R12: Writing the top address byte while busy abandons the outstanding request and any held shift, and restarts the stream at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 addr low, 1 addr mid, 2 addr high (start), 3 shift |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Window byte select: 0 low, 1 high |
| rd_data_o | output | 8 | Selected window byte |
| mem_req_o | output | 1 | Word request, held until mem_valid_i |
| mem_addr_o | output | 24 | Byte address of requested word |
| mem_valid_i | input | 1 | Word delivered this cycle |
| mem_data_i | input | 16 | Little-endian word |
| busy_o | output | 1 | A word fetch is outstanding |

## Verification
A shift write and the arrival of a refill word can happen in the same cycle. To provoke this, the bench sets the memory latency to one cycle, writes a shift that forces a refill, and then writes a second shift in the very next cycle, while mem_valid_i is high. The bench judges the result against a bit-level model of the stream. The final window must equal the stream advanced by both amounts, so the second shift must have been held and applied after the merge rather than lost or applied to the unmerged buffer. Back-to-back shifts during a slow fetch, and a restart during a fetch, cover the related orderings.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    REG_ADDR_LO  = 2'd0,
    REG_ADDR_MID = 2'd1,
    REG_ADDR_HI  = 2'd2,
    REG_SHIFT    = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_REFILL = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/bsr_addr_reg.sv
module bsr_addr_reg
  import bsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_mid_i,
  input  logic              start_i,
  input  logic [7:0]        data_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int STAGE_W = ADDR_W - 8;

  logic [STAGE_W-1:0] stage_q;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      if (we_lo_i)  stage_q[7:0]  <= data_i;
      if (we_mid_i) stage_q[15:8] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (start_i)   addr_q <= {data_i, stage_q};
    else if (advance_i) addr_q <= addr_q + ADDR_W'(2);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/bsr_bit_buffer.sv
module bsr_bit_buffer #(
  parameter int WIN_W = 16,
  localparam int BUF_W = 2 * WIN_W,
  localparam int CNT_W = $clog2(BUF_W) + 1,
  localparam int AMT_W = $clog2(WIN_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             refill_i,
  input  logic [WIN_W-1:0] word_i,
  input  logic             shift_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIN_W-1:0] win_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [BUF_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      buf_q <= BUF_W'(word_i);
      cnt_q <= CNT_W'(WIN_W);
    end else if (refill_i) begin
      // new word lands just above the surviving bits
      buf_q <= buf_q | (BUF_W'(word_i) << cnt_q);
      cnt_q <= cnt_q + CNT_W'(WIN_W);
    end else if (shift_i) begin
      buf_q <= buf_q >> amt_i;
      cnt_q <= cnt_q - CNT_W'(amt_i);
    end
  end

  assign win_o = buf_q[WIN_W-1:0];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int WIN_W = 16,
  localparam int BUF_W = 2 * WIN_W,
  localparam int CNT_W = $clog2(BUF_W) + 1,
  localparam int AMT_W = $clog2(WIN_W) + 1,
  localparam int FLD_W = $clog2(WIN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [FLD_W-1:0] amt_field_i,
  input  logic             mem_valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             start_o,
  output logic             load_o,
  output logic             refill_o,
  output logic             shift_o,
  output logic [AMT_W-1:0] amt_o,
  output logic             busy_o
);
  fetch_st_e        st_q, st_d;
  logic             pend_q;
  logic [AMT_W-1:0] pend_amt_q;
  logic             start_wr, shift_wr, idle, go;
  logic [AMT_W-1:0] amt_dec;
  logic [CNT_W:0]   refill_thr;

  assign start_wr = wr_en_i && (wr_sel_i == REG_ADDR_HI);
  assign shift_wr = wr_en_i && (wr_sel_i == REG_SHIFT);
  assign idle     = (st_q == ST_IDLE);
  assign amt_dec  = (amt_field_i == '0) ? AMT_W'(WIN_W) : AMT_W'(amt_field_i);

  assign load_o   = (st_q == ST_LOAD)   && mem_valid_i && !start_wr;
  assign refill_o = (st_q == ST_REFILL) && mem_valid_i && !start_wr;

  // held shift has priority over a fresh write in the same idle cycle
  always_comb begin
    go    = 1'b0;
    amt_o = amt_dec;
    if (idle && pend_q) begin
      go    = 1'b1;
      amt_o = pend_amt_q;
    end else if (idle && shift_wr && (cnt_i != '0)) begin
      go    = 1'b1;
    end
  end

  assign shift_o    = go && !start_wr;
  assign refill_thr = (CNT_W+1)'(WIN_W) + (CNT_W+1)'(amt_o);

  always_comb begin
    st_d = st_q;
    if (start_wr)                      st_d = ST_LOAD;
    else if (load_o || refill_o)       st_d = ST_IDLE;
    else if (shift_o && ({1'b0, cnt_i} < refill_thr)) st_d = ST_REFILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pend_q     <= 1'b0;
      pend_amt_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_wr) begin
        pend_q <= 1'b0;
      end else if (shift_wr && (!idle || pend_q)) begin
        pend_q     <= 1'b1;
        pend_amt_q <= amt_dec;
      end else if (idle && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign start_o = start_wr;
  assign busy_o  = !idle;
endmodule

// File: rtl/bitstream_reader.sv
module bitstream_reader
  import bsr_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_sel_i,
  output logic [7:0]        rd_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WIN_W-1:0]  mem_data_i,
  output logic              busy_o
);
  localparam int BUF_W = 2 * WIN_W;
  localparam int CNT_W = $clog2(BUF_W) + 1;
  localparam int AMT_W = $clog2(WIN_W) + 1;
  localparam int FLD_W = $clog2(WIN_W);

  logic             start, load, refill, shift;
  logic [AMT_W-1:0] amt;
  logic [WIN_W-1:0] win;
  logic [CNT_W-1:0] bit_cnt;

  bsr_ctrl #(.WIN_W(WIN_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .amt_field_i (wr_data_i[FLD_W-1:0]),
    .mem_valid_i (mem_valid_i),
    .cnt_i       (bit_cnt),
    .start_o     (start),
    .load_o      (load),
    .refill_o    (refill),
    .shift_o     (shift),
    .amt_o       (amt),
    .busy_o      (busy_o)
  );

  bsr_addr_reg i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_lo_i   (wr_en_i && (wr_sel_i == REG_ADDR_LO)),
    .we_mid_i  (wr_en_i && (wr_sel_i == REG_ADDR_MID)),
    .start_i   (start),
    .data_i    (wr_data_i),
    .advance_i (load || refill),
    .addr_o    (mem_addr_o)
  );

  bsr_bit_buffer #(.WIN_W(WIN_W)) i_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .refill_i (refill),
    .word_i   (mem_data_i),
    .shift_i  (shift),
    .amt_i    (amt),
    .win_o    (win),
    .cnt_o    (bit_cnt)
  );

  assign mem_req_o = busy_o;
  assign rd_data_o = win[{rd_sel_i, 3'b000} +: 8];
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker
  import bsr_pkg::*;
#(
  parameter int WIN_W = 16,
  localparam int CNT_W = $clog2(2 * WIN_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  bit_cnt
);
  logic start_wr;
  assign start_wr = wr_en_i && (wr_sel_i == REG_ADDR_HI);

  assert_start_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> mem_req_o);

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i && !start_wr |=> mem_req_o && $stable(mem_addr_o));

  assert_drop_after_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !start_wr |=> !busy_o);

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !start_wr |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(2));

  assert_idle_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (bit_cnt != '0) |-> bit_cnt >= CNT_W'(WIN_W));

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt < CNT_W'(2 * WIN_W));
endmodule

bind bitstream_reader bsr_checker #(.WIN_W(WIN_W)) i_bsr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .busy_o      (busy_o),
  .bit_cnt     (bit_cnt)
);

// File: tb/test_bitstream_reader.sv
`timescale 1ns/1ps
module test_bitstream_reader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [7:0]  wr_data_i = 8'd0;
  logic        rd_sel_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        mem_req_o;
  logic [23:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [15:0] mem_data_i = 16'd0;
  logic        busy_o;

  always #10 clk_i = ~clk_i;

  bitstream_reader i_bitstream_reader (.*);

  int errors = 0;
  int checks = 0;

  // memory model
  int          lat = 1;
  int          mcnt = 0;
  int          fetch_cnt = 0;
  logic [23:0] last_fetch = '0;
  logic [23:0] seen_addr = '0;

  function automatic logic [7:0] byte_at(logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h4B;
  endfunction

  always @(negedge clk_i) begin
    if (!mem_req_o || mem_valid_i) begin
      mem_valid_i = 1'b0;
      mcnt = 0;
    end
    if (mem_req_o) begin
      if (mem_addr_o != seen_addr) mcnt = 0;
      seen_addr = mem_addr_o;
      mcnt++;
      if (mcnt >= lat) begin
        mem_valid_i = 1'b1;
        mem_data_i  = {byte_at(mem_addr_o + 24'd1), byte_at(mem_addr_o)};
        fetch_cnt++;
        last_fetch  = mem_addr_o;
        mcnt = 0;
      end
    end
  end

  // reference stream model
  logic [23:0] base = '0;
  logic [23:0] nxt = '0;
  int          pos = 0;
  int          cnt = 0;

  function automatic logic sbit(int p);
    logic [7:0] b;
    b = byte_at(base + 24'(p / 8));
    return b[p % 8];
  endfunction

  function automatic logic [15:0] exp_win(int p, int v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (i < v) ? sbit(p + i) : 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  string       tag_q[$];
  logic [15:0] val_q[$];

  initial begin
    forever begin
      @(negedge clk_i);
      if (val_q.size() > 0) begin
        string       t;
        logic [15:0] e;
        logic [7:0]  lo, hi;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        #2 rd_sel_i = 1'b0;
        #1 lo = rd_data_o;
        rd_sel_i = 1'b1;
        #1 hi = rd_data_o;
        chk(t, {16'd0, hi, lo}, {16'd0, e});
      end
    end
  end

  task automatic push(string t);
    tag_q.push_back(t);
    val_q.push_back(exp_win(pos, 16));
    wait (val_q.size() == 0);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    #1;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic settle();
    int ok = 0;
    while (ok < 2) begin
      @(negedge clk_i);
      #1;
      if (!busy_o) ok++; else ok = 0;
    end
  endtask

  function automatic int amt_of(logic [7:0] v);
    return (v[3:0] == 4'd0) ? 16 : int'(v[3:0]);
  endfunction

  // returns 1 when a refill is expected
  function automatic bit model_shift(int s);
    pos += s;
    cnt -= s;
    if (cnt < 16) begin
      cnt += 16;
      nxt += 24'd2;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic start(logic [23:0] a, bit idle_chk);
    wr(2'd0, a[7:0]);
    wr(2'd1, a[15:8]);
    if (idle_chk) chk("R2 no request on low/mid writes", {31'd0, mem_req_o}, 32'd0);
    wr(2'd2, a[23:16]);
    base = a; pos = 0; cnt = 16; nxt = a + 24'd2;
    settle();
    chk("R2 first fetch address", {8'd0, last_fetch}, {8'd0, a});
    chk("R3 address advanced", {8'd0, mem_addr_o}, {8'd0, nxt});
    push("R3 first window");
  endtask

  task automatic shift(logic [7:0] v, string t);
    int f0;
    bit rf;
    f0 = fetch_cnt;
    wr(2'd3, v);
    rf = model_shift(amt_of(v));
    settle();
    chk(rf ? "R6 refill fetched" : "R7 no fetch", fetch_cnt - f0, rf ? 1 : 0);
    if (rf) chk("R6 refill address", {8'd0, last_fetch}, {8'd0, nxt - 24'd2});
    push(t);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 0);
    chk("R1 req", {31'd0, mem_req_o}, 0);
    chk("R1 addr", {8'd0, mem_addr_o}, 0);
    rd_sel_i = 1'b0; #1 chk("R1 low byte", {24'd0, rd_data_o}, 0);
    rd_sel_i = 1'b1; #1 chk("R1 high byte", {24'd0, rd_data_o}, 0);
    rst_ni = 1'b1;

    // R11 shift with no stream
    wr(2'd3, 8'h05);
    settle();
    chk("R11 no fetch", fetch_cnt, 0);
    rd_sel_i = 1'b0; #1 chk("R11 window unchanged", {24'd0, rd_data_o}, 0);

    lat = 1;
    start(24'h123456, 1'b1);
    shift(8'h03, "R5 shift 3");
    shift(8'h05, "R5 shift 5");
    shift(8'h00, "R4 zero means 16");
    shift(8'hF7, "R4 upper bits ignored");
    shift(8'h02, "R6 merged window");
    shift(8'h0F, "R5 shift 15");
    shift(8'h01, "R6 refill after 1");

    // R8/R10 peek during a slow refill
    begin
      int   s, pre;
      logic [7:0] lo, hi;
      logic [15:0] e;
      lat = 3;
      s = cnt - 15;
      wr(2'd3, 8'(s));
      pre = cnt - s;
      e = exp_win(pos + s, pre);
      @(negedge clk_i);
      #1;
      chk("R8 busy during fetch", {31'd0, busy_o}, 1);
      chk("R8 request held", {31'd0, mem_req_o}, 1);
      chk("R8 request address", {8'd0, mem_addr_o}, {8'd0, nxt});
      rd_sel_i = 1'b0; #1 lo = rd_data_o;
      rd_sel_i = 1'b1; #1 hi = rd_data_o;
      chk("R10 read while busy", {16'd0, hi, lo}, {16'd0, e});
      void'(model_shift(s));
      settle();
      push("R6 window after slow refill");
    end

    // R9 two shifts while busy: second replaces first
    begin
      int s;
      s = cnt - 15;
      wr(2'd3, 8'(s));
      void'(model_shift(s));
      wr(2'd3, 8'h06);
      wr(2'd3, 8'h09);
      chk("R9 writes landed while busy", {31'd0, busy_o}, 1);
      void'(model_shift(9));
      settle();
      push("R9 last pending shift applied");
    end

    // R9 shift in the same cycle the refill word arrives
    begin
      int  s;
      bit  coll;
      lat = 1;
      s = cnt - 15;
      wr(2'd3, 8'(s));
      void'(model_shift(s));
      @(negedge clk_i);
      #1;
      coll = mem_valid_i;
      wr_en_i = 1'b1; wr_sel_i = 2'd3; wr_data_i = 8'h0B;
      @(posedge clk_i);
      #1 wr_en_i = 1'b0;
      chk("R9 collision provoked", {31'd0, coll}, 1);
      void'(model_shift(11));
      settle();
      push("R9 shift held across word arrival");
    end

    // R12 restart while busy with a held shift
    begin
      int s;
      lat = 4;
      s = cnt - 15;
      wr(2'd3, 8'(s));
      wr(2'd3, 8'h04);
      start(24'h0A0FF1, 1'b0);
      shift(8'h07, "R12 stream after restart");
      shift(8'h0C, "R12 refill after restart");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule